// File: doc/BRIEF.md
# Two-Level Granule Protection Checker

This block decides whether a physical memory access may proceed, given the security state of the agent that issues it. A request carries a physical address and one of four requester states (root, realm, secure, non-secure). The checker first tests the address against the configured protected space. An address outside that space is allowed at once. Otherwise the checker walks an in-memory protection table over a simple read port. A level-0 entry either tags a whole region with a single physical-address-space (PAS) value, or points to a level-1 table that packs one 4-bit tag per granule, two granules to a byte.

The tag that results is then matched against the access matrix for the requester's state. The verdict comes back as a one-cycle `done` pulse with `allow` valid alongside it. Protected space size, granule size, level-0 region size and the level-0 table base are static configuration inputs. They must be held stable while a walk is in progress. Only one request is in flight at a time. `req_ready` shows when a new request can be accepted.

Top module: `gpc_checker`

## Requirements
- R1: Requester state encoding is 0 root, 1 realm, 2 secure, 3 non-secure. PAS tags are 4'h8 secure, 4'h9 non-secure, 4'hA root, 4'hB realm. Non-secure PAS is open to all four states. Secure PAS is open to root and secure. Realm PAS is open to root and realm. Root PAS is open to root only.
- R2: When the request address shifted right by the protected-space width is non-zero, the request is allowed. `done` rises in the cycle right after acceptance, and no memory read is issued.
- R3: The level-0 read address is the table base with bits [2:0] cleared, plus eight times (address >> level-0 region width).
- R4: A level-0 entry whose bits [3:0] equal 4'h1 is a block. Its tag is bits [7:4], and the walk ends after that single read.
- R5: A level-0 entry whose bits [3:0] equal 4'h3 is a table pointer. The level-1 table base is entry bits [51:12] followed by twelve zero bits. The granule index is (address mod region) >> granule width. The byte address is the base plus (granule index >> 1). It is read as the 8-byte-aligned 64-bit word that contains it, with byte lane = byte address [2:0], little-endian. The walk makes exactly two reads.
- R6: An even granule index takes its tag from bits [3:0] of the level-1 byte, and an odd index takes it from bits [7:4].
- R7: A level-0 entry with any other type code ends the walk as a fault (`allow`=0) after one read.
- R8: A tag outside the four listed in R1 faults for every requester, including root.
- R9: Size selects: protected space 0..6 give 32, 36, 40, 42, 44, 48 and 52 address bits (7 acts as 52). Granule select 0, 1, 2 give 12, 14 and 16 bits (3 acts as 16). Level-0 region select 0..3 gives 30, 34, 36 and 39 bits.
- R10: `req_ready` is high only when idle. `done` is a one-cycle pulse, followed by `req_ready` high. `allow` is 0 whenever `done` is 0. `mem_rd_en` is a one-cycle pulse per read, and the data is taken in the first cycle `mem_rd_valid` is high.
- R11: After a synchronous active-high reset, `req_ready`=1, and `done`, `allow` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pps | input | 3 | Protected space size select (R9) |
| cfg_pgs | input | 2 | Granule size select (R9) |
| cfg_l0sz | input | 2 | Level-0 region size select (R9) |
| cfg_l0_base | input | 52 | Level-0 table base address |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Checker idle, request accepted when valid |
| req_pa | input | 52 | Physical address to check |
| req_state | input | 2 | Requester security state |
| mem_rd_en | output | 1 | Table read request pulse |
| mem_rd_addr | output | 52 | 8-byte-aligned table read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read data word |
| done | output | 1 | Verdict pulse |
| allow | output | 1 | Access permitted (with done) |

## Verification
Directed requests run every requester state against each PAS tag through both a block entry and a packed level-1 table. These cases separate errors in the matrix from errors in nibble selection, byte-lane selection and descriptor-type decoding. Addresses on even and odd granules, on high byte lanes and with invalid tags or entry types show whether the correct nibble is taken and whether faults are raised. Random addresses under three size configurations, together with out-of-range addresses and random response latency, test the index arithmetic against a reference walk over the same table memory. The read count and the first read address show which path was taken, and they catch a walk that reads too much or at the wrong place.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    localparam int PA_W   = 52;
    localparam int DESC_W = 64;
    localparam int SH_W   = 6;

    typedef enum logic [1:0] {
        REQ_ROOT   = 2'd0,
        REQ_REALM  = 2'd1,
        REQ_SECURE = 2'd2,
        REQ_NONSEC = 2'd3
    } req_state_e;

    localparam logic [3:0] TAG_SECURE = 4'h8;
    localparam logic [3:0] TAG_NONSEC = 4'h9;
    localparam logic [3:0] TAG_ROOT   = 4'hA;
    localparam logic [3:0] TAG_REALM  = 4'hB;

    localparam logic [3:0] KIND_BLOCK = 4'h1;
    localparam logic [3:0] KIND_TABLE = 4'h3;

    typedef enum logic [2:0] {
        W_IDLE, W_L0_RD, W_L0_WT, W_L1_RD, W_L1_WT, W_DONE
    } walk_state_e;

    // level-0 entry view (8 bytes)
    typedef struct packed {
        logic [11:0] unused;
        logic [39:0] l1_page;
        logic [3:0]  rsvd;
        logic [3:0]  tag;
        logic [3:0]  kind;
    } l0_entry_t;

    function automatic logic [SH_W-1:0] space_shift(input logic [2:0] sel);
        case (sel)
            3'd0: return 6'd32;
            3'd1: return 6'd36;
            3'd2: return 6'd40;
            3'd3: return 6'd42;
            3'd4: return 6'd44;
            3'd5: return 6'd48;
            default: return 6'd52;
        endcase
    endfunction

    function automatic logic [SH_W-1:0] granule_shift(input logic [1:0] sel);
        case (sel)
            2'd0: return 6'd12;
            2'd1: return 6'd14;
            default: return 6'd16;
        endcase
    endfunction

    function automatic logic [SH_W-1:0] region_shift(input logic [1:0] sel);
        case (sel)
            2'd0: return 6'd30;
            2'd1: return 6'd34;
            2'd2: return 6'd36;
            default: return 6'd39;
        endcase
    endfunction
endpackage

// File: rtl/gpc_addr_calc.sv
module gpc_addr_calc
    import gpc_pkg::*;
#(
    parameter int AW = gpc_pkg::PA_W
) (
    input  logic [AW-1:0]   pa,
    input  logic [AW-1:0]   l0_base,
    input  logic [AW-1:0]   l1_base,
    input  logic [SH_W-1:0] gran_sh,
    input  logic [SH_W-1:0] reg_sh,
    output logic [AW-1:0]   l0_addr,
    output logic [AW-1:0]   l1_word,
    output logic [2:0]      l1_lane,
    output logic            nib_hi
);
    logic [AW-1:0] idx;
    logic [AW-1:0] offset;
    logic [AW-1:0] gran;
    logic [AW-1:0] byte_addr;

    always_comb begin
        idx       = pa >> reg_sh;
        l0_addr   = {l0_base[AW-1:3], 3'b000} + (idx << 3);
        offset    = pa & ~({AW{1'b1}} << reg_sh);
        gran      = offset >> gran_sh;
        nib_hi    = gran[0];
        byte_addr = l1_base + (gran >> 1);
        l1_word   = {byte_addr[AW-1:3], 3'b000};
        l1_lane   = byte_addr[2:0];
    end
endmodule

// File: rtl/gpc_access_matrix.sv
module gpc_access_matrix
    import gpc_pkg::*;
(
    input  req_state_e who,
    input  logic [3:0] tag,
    output logic       ok
);
    always_comb begin
        case (tag)
            TAG_NONSEC: ok = 1'b1;
            TAG_SECURE: ok = (who == REQ_ROOT) || (who == REQ_SECURE);
            TAG_REALM:  ok = (who == REQ_ROOT) || (who == REQ_REALM);
            TAG_ROOT:   ok = (who == REQ_ROOT);
            default:    ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker
    import gpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_pps,
    input  logic [1:0]        cfg_pgs,
    input  logic [1:0]        cfg_l0sz,
    input  logic [PA_W-1:0]   cfg_l0_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PA_W-1:0]   req_pa,
    input  logic [1:0]        req_state,
    output logic              mem_rd_en,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DESC_W-1:0] mem_rd_data,
    output logic              done,
    output logic              allow
);
    walk_state_e     state;
    logic [PA_W-1:0] pa_q;
    req_state_e      who_q;
    logic [PA_W-1:0] l1_base_q;
    logic            allow_q;

    logic [PA_W-1:0] l0_addr, l1_word;
    logic [2:0]      l1_lane;
    logic            nib_hi;
    logic            out_of_space;
    l0_entry_t       entry;
    logic [7:0]      l1_byte;
    logic [3:0]      tag_sel;
    logic            tag_ok;

    gpc_addr_calc #(.AW(PA_W)) u_calc (
        .pa      (pa_q),
        .l0_base (cfg_l0_base),
        .l1_base (l1_base_q),
        .gran_sh (granule_shift(cfg_pgs)),
        .reg_sh  (region_shift(cfg_l0sz)),
        .l0_addr (l0_addr),
        .l1_word (l1_word),
        .l1_lane (l1_lane),
        .nib_hi  (nib_hi)
    );

    gpc_access_matrix u_matrix (
        .who (who_q),
        .tag (tag_sel),
        .ok  (tag_ok)
    );

    always_comb begin
        out_of_space = (req_pa >> space_shift(cfg_pps)) != '0;
        entry        = l0_entry_t'(mem_rd_data);
        l1_byte      = 8'(mem_rd_data >> {l1_lane, 3'b000});
        if (state == W_L1_WT) tag_sel = nib_hi ? l1_byte[7:4] : l1_byte[3:0];
        else                  tag_sel = entry.tag;
    end

    assign req_ready   = (state == W_IDLE);
    assign mem_rd_en   = (state == W_L0_RD) || (state == W_L1_RD);
    assign mem_rd_addr = (state == W_L1_RD) ? l1_word : l0_addr;
    assign done        = (state == W_DONE);
    assign allow       = done & allow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            pa_q      <= '0;
            who_q     <= REQ_ROOT;
            l1_base_q <= '0;
            allow_q   <= 1'b0;
        end else begin
            case (state)
                W_IDLE: if (req_valid) begin
                    pa_q  <= req_pa;
                    who_q <= req_state_e'(req_state);
                    if (out_of_space) begin
                        allow_q <= 1'b1;
                        state   <= W_DONE;
                    end else begin
                        state <= W_L0_RD;
                    end
                end
                W_L0_RD: state <= W_L0_WT;
                W_L0_WT: if (mem_rd_valid) begin
                    if (entry.kind == KIND_BLOCK) begin
                        allow_q <= tag_ok;
                        state   <= W_DONE;
                    end else if (entry.kind == KIND_TABLE) begin
                        l1_base_q <= {entry.l1_page, 12'h000};
                        state     <= W_L1_RD;
                    end else begin
                        allow_q <= 1'b0;
                        state   <= W_DONE;
                    end
                end
                W_L1_RD: state <= W_L1_WT;
                W_L1_WT: if (mem_rd_valid) begin
                    allow_q <= tag_ok;
                    state   <= W_DONE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // R1
    nonsec_block_chk: assert property (@(posedge clk) disable iff (rst)
        (state == W_L0_WT && mem_rd_valid && entry.kind == KIND_BLOCK &&
         who_q == REQ_NONSEC && entry.tag != TAG_NONSEC) |=> (done && !allow));
    // R2
    out_of_space_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && out_of_space) |=> (done && allow && !mem_rd_en));
    // R7
    bad_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (state == W_L0_WT && mem_rd_valid && entry.kind != KIND_BLOCK &&
         entry.kind != KIND_TABLE) |=> (done && !allow));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);
    // R10
    allow_qual_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> !allow);
endmodule

// File: tb/gpc_checker_bench.sv
`timescale 1ns/1ps
module gpc_checker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_pps = 3'd0;
    logic [1:0]  cfg_pgs = 2'd0;
    logic [1:0]  cfg_l0sz = 2'd0;
    logic [51:0] cfg_l0_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [51:0] req_pa = '0;
    logic [1:0]  req_state = 2'd0;
    logic        mem_rd_en;
    logic [51:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        done;
    logic        allow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_count = 0;
    longint unsigned first_addr = 0;
    bit pend = 0;
    int lat_cnt = 0;
    longint unsigned pend_addr = 0;
    logic [63:0] mem [longint unsigned];

    gpc_checker u_gpc_checker (
        .clk(clk), .rst(rst), .cfg_pps(cfg_pps), .cfg_pgs(cfg_pgs),
        .cfg_l0sz(cfg_l0sz), .cfg_l0_base(cfg_l0_base), .req_valid(req_valid),
        .req_ready(req_ready), .req_pa(req_pa), .req_state(req_state),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .allow(allow)
    );

    always #2.5 clk = ~clk;

    function automatic logic [63:0] rdmem(longint unsigned a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    // memory responder: random latency, driven away from the active edge
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (pend) begin
            if (lat_cnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = rdmem(pend_addr);
                pend = 0;
            end else lat_cnt--;
        end
        if (mem_rd_en) begin
            if (rd_count == 0) first_addr = longint'(mem_rd_addr);
            rd_count++;
            pend = 1;
            pend_addr = longint'(mem_rd_addr);
            lat_cnt = $urandom_range(0, 2);
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R10 watchdog expired: actual hung, expected completion");
            summary();
            $finish;
        end
    end

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int sp_b(int s);
        int t[7] = '{32, 36, 40, 42, 44, 48, 52};
        return (s > 6) ? 52 : t[s];
    endfunction
    function automatic int gr_b(int s);
        return (s == 0) ? 12 : (s == 1) ? 14 : 16;
    endfunction
    function automatic int rg_b(int s);
        int t[4] = '{30, 34, 36, 39};
        return t[s];
    endfunction

    function automatic bit perm(int st, int tag);
        if (tag == 9)  return 1;
        if (tag == 10) return st == 0;
        if (tag == 11) return (st == 0) || (st == 1);
        if (tag == 8)  return (st == 0) || (st == 2);
        return 0;
    endfunction

    task automatic ref_walk(longint unsigned pa, int st, output bit ok,
                            output int nrd, output longint unsigned l0a);
        int pb = sp_b(cfg_pps);
        int gb = gr_b(cfg_pgs);
        int rb = rg_b(cfg_l0sz);
        logic [63:0] d, w;
        longint unsigned base, g, ba;
        int tag;
        l0a = 0;
        if ((pa >> pb) != 0) begin ok = 1; nrd = 0; return; end
        l0a = (longint'(cfg_l0_base) / 8) * 8 + (pa >> rb) * 8;
        d = rdmem(l0a);
        if (d[3:0] == 4'h1) begin
            ok = perm(st, int'(d[7:4])); nrd = 1;
        end else if (d[3:0] == 4'h3) begin
            base = longint'(d[51:12]) * 4096;
            g  = (pa % (64'd1 << rb)) / (64'd1 << gb);
            ba = base + g / 2;
            w  = rdmem((ba / 8) * 8);
            w  = w >> (8 * (ba % 8));
            tag = (g % 2 == 1) ? int'(w[7:4]) : int'(w[3:0]);
            ok = perm(st, tag); nrd = 2;
        end else begin
            ok = 0; nrd = 1;
        end
    endtask

    task automatic do_req(longint unsigned pa, int st, string lbl);
        bit eok; int enrd; longint unsigned el0; int lat;
        ref_walk(pa, st, eok, enrd, el0);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_count = 0;
        req_valid = 1'b1; req_pa = pa[51:0]; req_state = st[1:0];
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        if (!done) begin
            check({lbl, " no done"}, 0, 1);
            return;
        end
        check({lbl, " allow"}, allow, eok);
        check({lbl, " reads"}, rd_count, enrd);
        if (enrd > 0) check("R3 l0 address", first_addr, el0);
        else          check("R2 latency", lat, 1);
        @(negedge clk);
        check("R10 done pulse", done, 0);
        check("R10 ready after done", req_ready, 1);
    endtask

    task automatic fill_table(longint unsigned base);
        int tags[7] = '{8, 9, 10, 11, 0, 15, 1};
        for (int wd = 0; wd < 8; wd++) begin
            logic [63:0] v;
            for (int n = 0; n < 16; n++) v[n*4 +: 4] = 4'(tags[$urandom_range(0, 6)]);
            mem[base + wd * 8] = v;
        end
    endtask

    task automatic rand_phase(int nent, int n, string lbl);
        for (int i = 0; i < n; i++) begin
            longint unsigned pa;
            int gb = gr_b(cfg_pgs);
            if ($urandom_range(0, 7) == 0)
                pa = (64'd1 << sp_b(cfg_pps)) + longint'($urandom);
            else
                pa = (longint'($urandom_range(0, nent - 1)) << rg_b(cfg_l0sz)) |
                     (longint'($urandom_range(0, 63)) << gb) |
                     (longint'($urandom) & ((64'd1 << gb) - 1));
            do_req(pa, $urandom_range(0, 3), lbl);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 ready", req_ready, 1);
        check("R11 done", done, 0);
        check("R11 allow", allow, 0);
        check("R11 rd_en", mem_rd_en, 0);

        // config A: 4GB space, 4KB granules, 1GB regions
        cfg_pps = 3'd0; cfg_pgs = 2'd0; cfg_l0sz = 2'd0; cfg_l0_base = 52'h10000;
        mem[64'h10000] = 64'h91;
        mem[64'h10008] = 64'h200003;
        mem[64'h10010] = 64'hA1;
        mem[64'h10018] = 64'h5;
        mem[64'h200000] = 64'h00009B00_000F98BA;
        for (int st = 0; st < 4; st++) begin
            do_req(64'h0000_1234, st, "R4 block nonsec");
            do_req(64'h8000_0000, st, "R4 block root");
            do_req(64'hC000_0040, st, "R7 bad kind");
            do_req(64'h4000_0000, st, "R1 root tag");
            do_req(64'h4000_1000, st, "R6 odd granule realm");
            do_req(64'h4000_2000, st, "R1 secure tag");
            do_req(64'h4000_3000, st, "R6 odd granule nonsec");
            do_req(64'h4000_4000, st, "R8 tag F");
            do_req(64'h4000_5000, st, "R8 tag 0");
            do_req(64'h4000_A000, st, "R5 lane 5 even");
            do_req(64'h4000_B000, st, "R5 lane 5 odd");
            do_req(64'h1_0000_0000, st, "R2 out of space");
            do_req(64'h8_0000_0000_0000, st, "R2 top address");
        end
        fill_table(64'h200000);
        rand_phase(4, 80, "R5 random A");

        // config B: 64GB space, 64KB granules, 16GB regions
        cfg_pps = 3'd1; cfg_pgs = 2'd2; cfg_l0sz = 2'd1; cfg_l0_base = 52'h30000;
        mem[64'h30000] = 64'h400003;
        mem[64'h30008] = 64'h81;
        mem[64'h30010] = 64'h200003;
        mem[64'h30018] = 64'hB1;
        fill_table(64'h400000);
        rand_phase(4, 60, "R9 random B");

        // config C: 1TB space, 16KB granules, 512GB regions
        cfg_pps = 3'd2; cfg_pgs = 2'd1; cfg_l0sz = 2'd3; cfg_l0_base = 52'h50000;
        mem[64'h50000] = 64'h600003;
        mem[64'h50008] = 64'h91;
        fill_table(64'h600000);
        rand_phase(2, 60, "R9 random C");

        summary();
        $finish;
    end
endmodule